// File: doc/BRIEF.md
# Parity Bus Transceiver Channel with Error Flag Latch

One 8-bit channel links an A bus to a B bus. The B bus carries a ninth bit that holds parity. Two active-low side enables pick the direction. Going from A to B, the channel drives the A data onto the B side unchanged, together with a generated parity bit that makes the nine B bits odd. Going from B to A, it drives the B data onto the A side unchanged and checks the nine received B bits. If neither enable is asserted, both buses are isolated. If both are asserted, data goes from A to B with the parity bit inverted, so that an error is forced on purpose for system diagnostics.

The checker result passes through an error flag latch. The latch is transparent, holds its value, or is cleared. The error pin is open-drain. It is modelled as an active-low level plus an output enable that is high only while an error is shown. Each tristate pin is modelled as an input, an output and an output enable.

Direction decode is a four-state mode: `MODE_ISOLATE`, `MODE_A2B`, `MODE_B2A` and `MODE_A2B_FORCED`. The stored flag is a two-state machine with `FLAG_CLEAR` and `FLAG_ERR`. `FLAG_CLEAR -> FLAG_ERR` on a clock edge with the latch open, clear released and a live error present. `FLAG_ERR -> FLAG_CLEAR` on a clock edge with clear asserted, or with the latch open and no live error. Otherwise the state holds.

Top module: `pbx_channel`

## Requirements
- R1: With `oea_n`=1 and `oeb_n`=1 (isolate), `a_oe`=0 and `b_oe`=0.
- R2: With `oea_n`=1 and `oeb_n`=0 (A to B), `b_oe`=1, `a_oe`=0, `b_out`=`a_in`, and `b_par_out` is chosen so that the 9 bits {`b_out`,`b_par_out`} contain an odd number of ones.
- R3: With `oea_n`=0 and `oeb_n`=1 (B to A), `a_oe`=1, `b_oe`=0 and `a_out`=`b_in`.
- R4: In B to A, the live error is 1 exactly when {`b_in`,`b_par_in`} contains an even number of ones. This includes any single flipped bit among the nine.
- R5: With `oea_n`=0 and `oeb_n`=0 (forced error), `b_oe`=1, `a_oe`=0, `b_out`=`a_in`, and `b_par_out` is inverted so that the 9 B bits hold an even count of ones.
- R6: Outside B to A, the live error is 0 whatever `b_in` and `b_par_in` carry.
- R7: With `le`=0 and `clr_n`=1, the error pins follow the live error in the same cycle.
- R8: With `le`=1 and `clr_n`=1, the error pins show the flag stored at the last rising `clk` edge that saw `le`=0. Changes on the B bus or the enables have no effect.
- R9: `clr_n`=0 forces the pins to no-error at once and clears the stored flag at the next rising edge. It wins over `le`=0 with a live error.
- R10: The error pins are `err_n`=0 and `err_oe`=1 when an error is shown, and `err_n`=1 and `err_oe`=0 otherwise.
- R11: `rst_n`=0 clears the stored flag asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the error flag |
| rst_n | input | 1 | Asynchronous active-low reset of the stored flag |
| oea_n | input | 1 | Active-low enable for driving the A side |
| oeb_n | input | 1 | Active-low enable for driving the B side |
| le | input | 1 | Flag latch control: 0 transparent, 1 hold |
| clr_n | input | 1 | Active-low flag clear |
| a_in | input | 8 | Data received from the A bus |
| a_out | output | 8 | Data driven onto the A bus |
| a_oe | output | 1 | Drive enable for `a_out` |
| b_in | input | 8 | Data received from the B bus |
| b_par_in | input | 1 | Parity bit received from the B bus |
| b_out | output | 8 | Data driven onto the B bus |
| b_par_out | output | 1 | Parity bit driven onto the B bus |
| b_oe | output | 1 | Drive enable for `b_out` and `b_par_out` |
| err_n | output | 1 | Active-low error level |
| err_oe | output | 1 | Open-drain enable for `err_n` |

## Verification
The bench sweeps all nine single-bit flips of a correct B word. A checker that watched only the data byte, or that looked for even parity, would miss some of these or flag them backwards. It sends bad B parity in the A-to-B and isolate modes, where an unqualified checker would raise a false error. It drives both enables low, where a design that forgot the inversion would emit legal parity. A latch sequence holds a captured error across good data, then clears it while held and while open with a live error. This catches a latch that follows its input while closed, a clear that loses to `le`, and a reset that does not reach the stored flag.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE    = 2'd0,
        MODE_A2B        = 2'd1,
        MODE_B2A        = 2'd2,
        MODE_A2B_FORCED = 2'd3
    } pbx_mode_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_ERR   = 1'b1
    } pbx_flag_e;
endpackage

// File: rtl/pbx_dir_decode.sv
module pbx_dir_decode
    import pbx_pkg::*;
(
    input  logic      oea_n,
    input  logic      oeb_n,
    output pbx_mode_e mode,
    output logic      a_oe,
    output logic      b_oe,
    output logic      force_inv
);
    always_comb begin
        unique case ({oea_n, oeb_n})
            2'b11:   mode = MODE_ISOLATE;
            2'b10:   mode = MODE_A2B;
            2'b01:   mode = MODE_B2A;
            default: mode = MODE_A2B_FORCED;
        endcase
    end

    always_comb begin
        a_oe      = 1'b0;
        b_oe      = 1'b0;
        force_inv = 1'b0;
        unique case (mode)
            MODE_ISOLATE:    ;
            MODE_A2B:        b_oe = 1'b1;
            MODE_B2A:        a_oe = 1'b1;
            MODE_A2B_FORCED: begin
                b_oe      = 1'b1;
                force_inv = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pbx_parity.sv
module pbx_parity #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gen_data,
    input  logic             force_inv,
    input  logic [WIDTH-1:0] chk_data,
    input  logic             chk_par,
    input  logic             chk_en,
    output logic             par_gen,
    output logic             par_err
);
    localparam int CHK_BITS = WIDTH + 1;

    logic [WIDTH-1:0]    gen_chain;
    logic [CHK_BITS-1:0] chk_word;
    logic [CHK_BITS-1:0] chk_chain;

    assign chk_word = {chk_par, chk_data};

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_gen
            if (i == 0) begin : g_first
                assign gen_chain[i] = gen_data[i];
            end else begin : g_next
                assign gen_chain[i] = gen_chain[i-1] ^ gen_data[i];
            end
        end
        for (genvar j = 0; j < CHK_BITS; j++) begin : g_chk
            if (j == 0) begin : g_first
                assign chk_chain[j] = chk_word[j];
            end else begin : g_next
                assign chk_chain[j] = chk_chain[j-1] ^ chk_word[j];
            end
        end
    endgenerate

    // odd total: parity bit is the complement of the data XOR
    assign par_gen = ~gen_chain[WIDTH-1] ^ force_inv;
    assign par_err = chk_en & ~chk_chain[CHK_BITS-1];
endmodule

// File: rtl/pbx_err_latch.sv
module pbx_err_latch
    import pbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le,
    input  logic clr_n,
    input  logic live_err,
    output logic flag_o
);
    pbx_flag_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (clr_n && !le && live_err)          state_d = FLAG_ERR;
            FLAG_ERR:   if (!clr_n || (!le && !live_err))      state_d = FLAG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!clr_n)  flag_o = 1'b0;
        else if (!le) flag_o = live_err;
        else          flag_o = (state_q == FLAG_ERR);
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (le && $past(le) && clr_n && $past(clr_n) && $past(rst_n)) |-> $stable(flag_o)) // R8
        else $error("held flag changed");
endmodule

// File: rtl/pbx_channel.sv
module pbx_channel
    import pbx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oea_n,
    input  logic             oeb_n,
    input  logic             le,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_par_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_par_out,
    output logic             b_oe,
    output logic             err_n,
    output logic             err_oe
);
    pbx_mode_e mode;
    logic      force_inv;
    logic      live_err;
    logic      flag;

    pbx_dir_decode u_dir (
        .oea_n     (oea_n),
        .oeb_n     (oeb_n),
        .mode      (mode),
        .a_oe      (a_oe),
        .b_oe      (b_oe),
        .force_inv (force_inv)
    );

    pbx_parity #(.WIDTH(WIDTH)) u_par (
        .gen_data  (a_in),
        .force_inv (force_inv),
        .chk_data  (b_in),
        .chk_par   (b_par_in),
        .chk_en    (mode == MODE_B2A),
        .par_gen   (b_par_out),
        .par_err   (live_err)
    );

    pbx_err_latch u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (le),
        .clr_n    (clr_n),
        .live_err (live_err),
        .flag_o   (flag)
    );

    assign a_out  = b_in;
    assign b_out  = a_in;
    assign err_n  = ~flag;
    assign err_oe = flag;

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_oe && b_oe)) // R1
        else $error("both sides driven");
    AST_PAR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && oea_n) |-> (^{b_out, b_par_out})) // R2
        else $error("generated parity not odd");
    AST_PAR_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !oea_n) |-> !(^{b_out, b_par_out})) // R5
        else $error("forced parity not inverted");
    AST_NO_CHECK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!oea_n && oeb_n) && !le) |-> err_n) // R6
        else $error("error outside B to A");
    AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!oea_n && oeb_n && !le && clr_n) |-> (err_n == ^{b_in, b_par_in})) // R7
        else $error("open latch not following checker");
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (err_n && !err_oe)) // R9
        else $error("clear did not win");
endmodule

// File: tb/pbx_channel_bench.sv
`timescale 1ns/100ps
module pbx_channel_bench;
    localparam int W = 8;

    typedef struct {
        logic         a_oe;
        logic         b_oe;
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic         b_par;
        logic         err;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oea_n = 1'b1, oeb_n = 1'b1, le = 1'b0, clr_n = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic b_par_in = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe, b_par_out, err_n, err_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pbx_channel #(.WIDTH(W)) u_pbx_channel (
        .clk(clk), .rst_n(rst_n), .oea_n(oea_n), .oeb_n(oeb_n), .le(le), .clr_n(clr_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_par_in(b_par_in),
        .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe), .err_n(err_n), .err_oe(err_oe)
    );

    function automatic logic odd9(input logic [W-1:0] d, input logic p);
        int c = 0;
        for (int i = 0; i < W; i++) c += d[i];
        c += p;
        return (c % 2) == 1;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // driver: apply stimulus at negedge, push expectation derived from requirements
    task automatic step(input logic ea, input logic eb, input logic l, input logic c,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic bp,
                        input logic exp_err, input string tag);
        exp_t e;
        @(negedge clk);
        oea_n = ea; oeb_n = eb; le = l; clr_n = c; a_in = a; b_in = b; b_par_in = bp;
        #1;
        e.a_oe  = !ea && eb;
        e.b_oe  = !eb;
        e.a_out = b;
        e.b_out = a;
        e.b_par = !odd9(a, 1'b0) ^ (!ea && !eb);   // odd total, inverted when forced
        e.err   = exp_err;
        e.tag   = tag;
        q.push_back(e);
    endtask

    // monitor: pop and compare
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            check({e.tag, " a_oe"}, a_oe, e.a_oe);
            check({e.tag, " b_oe"}, b_oe, e.b_oe);
            if (e.a_oe) check({e.tag, " a_out"}, (a_out == e.a_out), 1'b1);
            if (e.b_oe) begin
                check({e.tag, " b_out"}, (b_out == e.b_out), 1'b1);
                check({e.tag, " b_par"}, b_par_out, e.b_par);
            end
            check({e.tag, " err_n R10"}, err_n, !e.err);
            check({e.tag, " err_oe R10"}, err_oe, e.err);
        end
    end

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b;
        logic gp;
        // reset state (R11, R1)
        #1;
        check("R11 reset err_n", err_n, 1'b1);
        check("R1 reset a_oe", a_oe, 1'b0);
        check("R1 reset b_oe", b_oe, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 isolate with bad B parity (also R6)
        for (int i = 0; i < 6; i++) begin
            a = W'($urandom); b = W'($urandom);
            step(1, 1, 0, 1, a, b, odd9(b, 1'b0), 1'b0, "R1 R6 isolate");
        end
        // R2 A to B, random plus edges, bad B parity ignored (R6)
        step(1, 0, 0, 1, 8'h00, 8'h00, 1'b0, 1'b0, "R2 zero");
        step(1, 0, 0, 1, 8'hFF, 8'h01, 1'b0, 1'b0, "R2 ones R6");
        for (int i = 0; i < 20; i++) begin
            a = W'($urandom); b = W'($urandom);
            step(1, 0, 0, 1, a, b, odd9(b, 1'b0), 1'b0, "R2 R6 a2b");
        end
        // R5 forced
        for (int i = 0; i < 10; i++) begin
            a = W'($urandom); b = W'($urandom);
            step(0, 0, 0, 1, a, b, odd9(b, 1'b0), 1'b0, "R5 forced");
        end
        // R3 R4 B to A: good words, then single-bit flips in all nine positions
        for (int i = 0; i < 20; i++) begin
            b = W'($urandom); gp = !odd9(b, 1'b0);
            step(0, 1, 0, 1, W'($urandom), b, gp, 1'b0, "R3 R4 good");
        end
        for (int k = 0; k < W + 1; k++) begin
            b = W'($urandom); gp = !odd9(b, 1'b0);
            if (k < W) b[k] = ~b[k]; else gp = ~gp;
            step(0, 1, 0, 1, W'($urandom), b, gp, 1'b1, "R4 R7 flip");
        end
        // latch sequence
        step(0, 1, 0, 1, 8'h00, 8'h03, 1'b0, 1'b1, "R7 open err");
        step(0, 1, 1, 1, 8'h00, 8'h03, 1'b1, 1'b1, "R8 hold over good");
        step(1, 0, 1, 1, 8'h5A, 8'h00, 1'b1, 1'b1, "R8 hold over a2b");
        step(1, 1, 1, 1, 8'h5A, 8'h00, 1'b1, 1'b1, "R8 hold isolate");
        step(0, 1, 1, 0, 8'h00, 8'h03, 1'b0, 1'b0, "R9 clear while held");
        step(0, 1, 1, 1, 8'h00, 8'h03, 1'b0, 1'b0, "R9 R8 stays cleared");
        step(0, 1, 0, 0, 8'h00, 8'h03, 1'b0, 1'b0, "R9 clear beats open");
        step(0, 1, 1, 1, 8'h00, 8'h03, 1'b0, 1'b0, "R9 stored cleared");
        step(0, 1, 0, 1, 8'h00, 8'h07, 1'b0, 1'b0, "R7 open good");
        step(0, 1, 0, 1, 8'h00, 8'h07, 1'b1, 1'b1, "R7 open err2");
        step(0, 1, 1, 1, 8'h00, 8'h07, 1'b0, 1'b1, "R8 held err2");
        // R11 asynchronous reset of the stored flag
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 reset clears held flag", err_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 1, 1, 8'h00, 8'h07, 1'b0, 1'b0, "R11 R8 after reset");
        wait (q.size() == 0);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule